// File: doc/BRIEF.md
# Two-Phase Pixel Port Demultiplexer

This block sits behind a narrow parallel video input. A graphics controller sends each 24-bit pixel as two 12-bit halves on one port. Horizontal sync, vertical sync and data-enable travel beside the halves. The block captures the halves, pairs them into whole pixels and presents one pixel per pixel period. Each pixel leaves with the sync and enable values that arrived with its first half. A strobe marks every output update.

Two capture schemes are supported, selected by a static mode input.
- In the pixel-rate clock scheme, both clock edges carry data, one half per edge.
- In the double-rate clock scheme, one edge carries data and every second sample starts a new pixel. Pairing in this scheme re-locks to the start of active video.

A phase-select input moves every capture onto the opposite clock edge. Line length and frame height are free. The block counts nothing across a line.

Top module: `pxdmx_top`

## Requirements
- R1: The output pixel places the first half in bits [11:0] and the second half in bits [23:12].
- R2: With `mode_2x`=0 and `clk_inv`=0, the first half is sampled on a rising edge and the second half on the falling edge that follows.
- R3: With `clk_inv`=1, every sample moves to the opposite edge. With `mode_2x`=0, the first half is sampled on a falling edge and the second on the next rising edge. With `mode_2x`=1, both halves are sampled on consecutive falling edges.
- R4: With `mode_2x`=1 and `clk_inv`=0, both halves are sampled on consecutive rising edges. Values present only at falling edges have no effect on any output.
- R5: A pixel is loaded onto the outputs at the second rising edge strictly after the edge that sampled its second half. `pix_stb` is high for exactly the cycle that follows that load.
- R6: With `mode_2x`=0, `pix_stb` stays high on every cycle once it has risen. With `mode_2x`=1, `pix_stb` is never high on two consecutive cycles.
- R7: With `mode_2x`=1, a sample whose data-enable is 1 is taken as a first half if the previously used sample's data-enable was 0. This holds whatever the pairing phase was before.
- R8: `hsync_out` and `vsync_out` carry the values sampled together with the pixel's first half. Sync values presented with the second half are ignored.
- R9: `de_out` is 1 exactly for pixels whose first half was sampled with data-enable at 1.
- R10: While `rst_n` is low at a rising edge, all outputs clear to zero on that edge. `mode_2x` and `clk_inv` may change only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, at pixel rate or at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_2x | input | 1 | 1: double-rate clock, one edge used; 0: pixel-rate clock, both edges used |
| clk_inv | input | 1 | 1: capture on the opposite clock edges |
| half_in | input | 12 | Multiplexed pixel half |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data-enable, high during active video |
| pix_out | output | 24 | Reassembled pixel |
| hsync_out | output | 1 | Horizontal sync aligned to `pix_out` |
| vsync_out | output | 1 | Vertical sync aligned to `pix_out` |
| de_out | output | 1 | Pixel valid flag |
| pix_stb | output | 1 | Output update strobe |

## Verification
The hardest case to reach is the double-rate re-lock. Blanking must end on the second half of a free-running pair, so that the first active sample would otherwise be taken as a second half. The stimulus sweeps zero to three blanking samples before each active run, in both double-rate phase settings, so both pairing parities meet the enable edge. On the unused clock edge the stimulus drives inverted data and inverted sideband, so a capture on the wrong edge corrupts the result where the checks can see it.

// File: rtl/pxdmx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pixel port demultiplexer.
package pxdmx_pkg;
    localparam int HALF_W_DEF = 12;

    // Sideband values that travel with each sample.
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } side_t;
endpackage

// File: rtl/pxdmx_capture.sv
`timescale 1ns/1ps
// Edge capture stage.
// Samples the half port and sideband on the rising edge and, separately,
// on the falling edge. Assumes inputs are stable around both edges when
// the selected mode uses them. Reset is synchronous; the falling-edge bank
// sees the same reset level half a cycle later.
module pxdmx_capture
    import pxdmx_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_in,
    input  side_t             side_in,
    output logic [HALF_W-1:0] rise_half,
    output side_t             rise_side,
    output logic [HALF_W-1:0] fall_half,
    output side_t             fall_side
);
    // Rising-edge sample bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_half <= '0;
            rise_side <= '0;
        end else begin
            rise_half <= half_in;
            rise_side <= side_in;
        end
    end

    // Falling-edge sample bank.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_half <= '0;
            fall_side <= '0;
        end else begin
            fall_half <= half_in;
            fall_side <= side_in;
        end
    end
endmodule

// File: rtl/pxdmx_pair_1x.sv
`timescale 1ns/1ps
// Pixel-rate pairing path.
// Builds one pixel per cycle from a rising-edge half and a falling-edge
// half. Normal phase: the first half is on the rising edge and the second
// on the following falling edge. Inverted phase: the first half is on the
// falling edge and the second on the next rising edge. Two register
// stages; the strobe rises two cycles after reset and then stays high.
module pxdmx_pair_1x
    import pxdmx_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic [HALF_W-1:0] half_live,
    input  side_t             side_live,
    input  logic [HALF_W-1:0] fall_half,
    input  side_t             fall_side,
    output logic [PIX_W-1:0]  pix,
    output side_t             side,
    output logic              stb
);
    logic [HALF_W-1:0] s1_lo;
    logic [HALF_W-1:0] s1_hi;
    side_t             s1_side;
    logic              s1_vld;

    // Stage 1: take the rising-edge half and the sideband of the first half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_lo   <= '0;
            s1_hi   <= '0;
            s1_side <= '0;
            s1_vld  <= 1'b0;
        end else begin
            s1_vld <= 1'b1;
            if (inv) begin
                s1_lo   <= fall_half;
                s1_hi   <= half_live;
                s1_side <= fall_side;
            end else begin
                s1_lo   <= half_live;
                s1_side <= side_live;
            end
        end
    end

    // Stage 2: join the halves into one pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix  <= '0;
            side <= '0;
            stb  <= 1'b0;
        end else begin
            stb  <= s1_vld;
            side <= s1_side;
            if (inv) begin
                pix <= {s1_hi, s1_lo};
            end else begin
                pix <= {fall_half, s1_lo};
            end
        end
    end
endmodule

// File: rtl/pxdmx_pair_2x.sv
`timescale 1ns/1ps
// Double-rate pairing path.
// Consumes one sample per rising edge. Samples alternate between first and
// second halves. A rising data-enable forces the current sample to be a
// first half. Emits one pixel with a one-cycle strobe after each second
// half. Assumes the caller has already picked the sample edge.
module pxdmx_pair_2x
    import pxdmx_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] smp_half,
    input  side_t             smp_side,
    output logic [PIX_W-1:0]  pix,
    output side_t             side,
    output logic              stb
);
    logic              half_q;
    logic              prev_de;
    logic [HALF_W-1:0] hold_lo;
    side_t             hold_side;
    logic              take_first;

    // Decide whether the current sample opens a new pixel.
    always_comb begin
        take_first = !half_q || (smp_side.de && !prev_de);
    end

    // Track the half phase, hold the first half, emit the joined pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q    <= 1'b0;
            prev_de   <= 1'b0;
            hold_lo   <= '0;
            hold_side <= '0;
            pix       <= '0;
            side      <= '0;
            stb       <= 1'b0;
        end else begin
            prev_de <= smp_side.de;
            stb     <= 1'b0;
            if (take_first) begin
                hold_lo   <= smp_half;
                hold_side <= smp_side;
                half_q    <= 1'b1;
            end else begin
                pix    <= {smp_half, hold_lo};
                side   <= hold_side;
                stb    <= 1'b1;
                half_q <= 1'b0;
            end
        end
    end

    // A rising enable always opens a pixel and never closes one.
    p_first_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_side.de && !prev_de) |=> (half_q && !stb));
endmodule

// File: rtl/pxdmx_top.sv
`timescale 1ns/1ps
// Pixel port demultiplexer top.
// Captures 12-bit halves on both clock edges. It routes them to the
// pixel-rate or the double-rate pairing path and registers the chosen
// pixel with its sideband and an update strobe. Assumes mode_2x and
// clk_inv change only during reset.
module pxdmx_top
    import pxdmx_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    localparam int PIX_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_2x,
    input  logic              clk_inv,
    input  logic [HALF_W-1:0] half_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              de_in,
    output logic [PIX_W-1:0]  pix_out,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic              de_out,
    output logic              pix_stb
);
    side_t             side_in;
    logic [HALF_W-1:0] rise_half, fall_half, smp_half;
    side_t             rise_side, fall_side, smp_side;
    logic [PIX_W-1:0]  pix_a, pix_b, pix_sel;
    side_t             side_a, side_b, side_sel;
    logic              stb_a, stb_b, stb_sel;

    // Bundle the sideband inputs.
    always_comb begin
        side_in = '{de: de_in, hs: hsync_in, vs: vsync_in};
    end

    pxdmx_capture #(.HALF_W(HALF_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_in   (half_in),
        .side_in   (side_in),
        .rise_half (rise_half),
        .rise_side (rise_side),
        .fall_half (fall_half),
        .fall_side (fall_side)
    );

    pxdmx_pair_1x #(.HALF_W(HALF_W)) u_p1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv       (clk_inv),
        .half_live (half_in),
        .side_live (side_in),
        .fall_half (fall_half),
        .fall_side (fall_side),
        .pix       (pix_a),
        .side      (side_a),
        .stb       (stb_a)
    );

    // Double-rate sample stream: the falling bank when inverted, else the rising bank.
    always_comb begin
        smp_half = clk_inv ? fall_half : rise_half;
        smp_side = clk_inv ? fall_side : rise_side;
    end

    pxdmx_pair_2x #(.HALF_W(HALF_W)) u_p2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_half (smp_half),
        .smp_side (smp_side),
        .pix      (pix_b),
        .side     (side_b),
        .stb      (stb_b)
    );

    // Pick the active pairing path.
    always_comb begin
        pix_sel  = mode_2x ? pix_b  : pix_a;
        side_sel = mode_2x ? side_b : side_a;
        stb_sel  = mode_2x ? stb_b  : stb_a;
    end

    // Output register, loaded only on a completed pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            hsync_out <= 1'b0;
            vsync_out <= 1'b0;
            de_out    <= 1'b0;
            pix_stb   <= 1'b0;
        end else begin
            pix_stb <= stb_sel;
            if (stb_sel) begin
                pix_out   <= pix_sel;
                hsync_out <= side_sel.hs;
                vsync_out <= side_sel.vs;
                de_out    <= side_sel.de;
            end
        end
    end

    p_cadence_1x_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_2x && $past(pix_stb)) |-> pix_stb);

    p_cadence_2x_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_2x && pix_stb) |=> !pix_stb);

    p_mode_static_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_2x) && $stable(clk_inv)));
endmodule

// File: tb/sim_pxdmx_top.sv
`timescale 1ns/1ps
module sim_pxdmx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_2x = 1'b0;
    logic        clk_inv = 1'b0;
    logic [11:0] half_in = '0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        de_in = 1'b0;
    logic [23:0] pix_out;
    logic        hsync_out, vsync_out, de_out, pix_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cur_b = 0;

    // Expected active pixels of the current run.
    logic [23:0] exp_pix [0:15];
    logic        exp_hs  [0:15];
    logic        exp_vs  [0:15];
    longint      exp_t   [0:15];
    int wr = 0;
    int rd = 0;

    always #4 clk = ~clk;

    pxdmx_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_2x(mode_2x), .clk_inv(clk_inv),
        .half_in(half_in), .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
        .pix_out(pix_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
        .de_out(de_out), .pix_stb(pix_stb)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one half slot; called at times 2 mod 4, capture edge 2 ns later.
    task automatic drive(input logic [11:0] d, input logic de, input logic hs, input logic vs);
        half_in  = d;
        de_in    = de;
        hsync_in = hs;
        vsync_in = vs;
        #4;
    endtask

    // Place one half on the next used edge; in double-rate mode spoil the unused edge.
    task automatic put_half(input logic [11:0] d, input logic de, input logic hs,
                            input logic vs, output longint cap_t);
        cap_t = $time + 2;
        drive(d, de, hs, vs);
        if (mode_2x) drive(d ^ 12'hA5A, ~de, ~hs, ~vs);
    endtask

    task automatic run(input bit m2x, input bit inv, input int b, input int pat);
        longint t1, t2;
        logic [11:0] lo, hi;
        rst_n = 1'b0;
        mode_2x = m2x;
        clk_inv = inv;
        cur_b = b;
        for (int i = 0; i < 6; i++) drive(12'h0, 1'b0, 1'b0, 1'b0);
        // R10: outputs cleared under reset
        chk(pix_stb == 1'b0, "R10 reset strobe", pix_stb, 0);
        chk(de_out == 1'b0 && hsync_out == 1'b0 && vsync_out == 1'b0, "R10 reset sideband",
            {de_out, hsync_out, vsync_out}, 0);
        chk(pix_out == 24'h0, "R10 reset pixel", pix_out, 0);
        wr = 0;
        rd = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) drive(12'h0, 1'b0, 1'b0, 1'b0);
        while (((($time + 2) / 4) % 2) != (inv ? 0 : 1)) drive(12'h0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < (m2x ? b : 2 * b); i++) put_half(12'h3C3, 1'b0, 1'b1, 1'b0, t1);
        for (int p = 0; p < 6; p++) begin
            if (pat == 0) begin
                lo = 12'(p * 12'h111 + b * 7 + int'(m2x) * 3 + int'(inv));
                hi = ~lo ^ 12'(p);
            end else begin
                lo = 12'(1 << (p + 6 * int'(inv)));
                hi = 12'(12'h800 >> (p + 6 * int'(m2x)));
            end
            put_half(lo, 1'b1, p[0], p[1], t1);
            put_half(hi, 1'b1, ~p[0], ~p[1], t2);
            exp_pix[wr] = {hi, lo};
            exp_hs[wr]  = p[0];
            exp_vs[wr]  = p[1];
            exp_t[wr]   = (((t2 / 4) % 2) == 1) ? t2 + 16 : t2 + 12;
            wr++;
        end
        for (int i = 0; i < 16; i++) drive(12'h0, 1'b0, 1'b0, 1'b0);
        // R5: every pixel reached the outputs
        chk(rd == wr, "R5 pixels delivered", rd, wr);
    endtask

    // Output monitor, sampling 1 ns after each rising edge.
    initial begin
        bit prev_stb = 1'b0;
        int rs_cnt = 0;
        string tag;
        forever begin
            @(posedge clk);
            #1;
            rs_cnt = rst_n ? rs_cnt + 1 : 0;
            if (rst_n && mode_2x && pix_stb) chk(!prev_stb, "R6 double-rate spacing", prev_stb, 0);
            if (!mode_2x && rs_cnt > 4) chk(pix_stb, "R6 pixel-rate cadence", pix_stb, 1);
            if (rst_n && pix_stb && de_out) begin
                if (rd >= wr) begin
                    chk(1'b0, "R9 unexpected valid pixel", pix_out, 0);
                end else begin
                    if (mode_2x && (cur_b % 2 == 1)) tag = "R7 relock R1";
                    else if (clk_inv) tag = "R3 inverted R1";
                    else if (mode_2x) tag = "R4 double-rate R1";
                    else tag = "R2 pixel-rate R1";
                    chk(pix_out == exp_pix[rd], tag, pix_out, exp_pix[rd]);
                    chk(hsync_out == exp_hs[rd] && vsync_out == exp_vs[rd], "R8 sideband",
                        {hsync_out, vsync_out}, {exp_hs[rd], exp_vs[rd]});
                    chk(($time - 1) == exp_t[rd], "R5 latency", $time - 1, exp_t[rd]);
                    rd++;
                end
            end
            prev_stb = pix_stb;
        end
    end

    initial begin
        #2;
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 4; b++)
                for (int pat = 0; pat < 2; pat++)
                    run(m[1], m[0], b, pat);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            chk(1'b0, "R5 watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule